// File: doc/BRIEF.md
# Condition Flag Set/Clear Unit

This unit recognises the processor's flag-operate instruction group and applies it to the four-bit arithmetic flag register holding the negative (N), zero (Z), overflow (V) and carry (C) flags. One instruction names any subset of the four flags through a mask field. A single sense bit says whether that subset is forced to one or forced to zero. Flags outside the mask keep their value. An empty mask makes the instruction a no-operation, whichever way the sense bit points.

The instruction decoder presents the fetched word on `instr_i` and pulses `exec_i` in the cycle the instruction retires. `match_o` tells the surrounding decode logic, in the same cycle and without a clock edge, that the word belongs to this group. The flag register changes only on a clock edge where both the strobe and the match are high. The register contents appear on `flags_o` and serve as the current flags for the next instruction.

Top module: `ccop_unit`

## Requirements
- R1: `match_o` is high exactly when `instr_i[15:5]` equals binary 00000000101. It is combinational from `instr_i`.
- R2: On a clock edge with `exec_i` and `match_o` high and `instr_i[4]` = 1, every flag whose mask bit is 1 becomes 1. The mask bits are `instr_i[3]` = N, `instr_i[2]` = Z, `instr_i[1]` = V and `instr_i[0]` = C. `flags_o` uses the same bit positions.
- R3: On such an edge with `instr_i[4]` = 0, every flag whose mask bit is 1 becomes 0.
- R4: On such an edge, every flag whose mask bit is 0 keeps its previous value.
- R5: Octal 000240 and octal 000260 carry an empty mask and leave all four flags unchanged.
- R6: Octal 000257 clears all four flags. Octal 000277 sets all four flags.
- R7: Combined masks act on all their flags at once. Octal 000243 clears V and C only, and octal 000274 sets N and Z only.
- R8: On an edge where `exec_i` is low, or where the word does not match the group, `flags_o` does not change.
- R9: A clock edge with `rst` high clears all four flags to 0, whatever `exec_i` and `instr_i` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word under execution |
| exec_i | input | 1 | Execute strobe for the current word |
| match_o | output | 1 | Word belongs to the flag-operate group |
| flags_o | output | 4 | Flag register: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |

## Verification
The bench sends words that differ from the group prefix in a single bit, including neighbours just above and below the group. A decoder that compares too few prefix bits would raise `match_o` and alter flags on foreign instructions. Both empty-mask encodings are applied over several flag patterns, so a design that treats the sense bit as a mask member, or clears the register on a no-operation, changes `flags_o`. Partial masks are applied to registers preloaded with the opposite values, and matching words are presented with the strobe low. These cases expose designs that rewrite unmasked flags or update without the strobe.

// File: rtl/ccop_pkg.sv
package ccop_pkg;
    localparam int WORD_W   = 16;
    localparam int CC_W     = 4;
    localparam int SENSE_B  = CC_W;
    localparam int PREFIX_W = WORD_W - CC_W - 1;

    localparam logic [PREFIX_W-1:0] GROUP_CODE = 11'b00000000101;

    typedef logic [CC_W-1:0] cc_t;

    typedef struct packed {
        logic hit;
        logic sense;
        cc_t  mask;
    } cc_op_t;

    typedef struct packed {
        cc_t flags;
    } cc_state_t;
endpackage

// File: rtl/ccop_decode.sv
module ccop_decode
    import ccop_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output cc_op_t            op_o
);
    always_comb begin
        op_o.hit   = (instr_i[WORD_W-1 -: PREFIX_W] == GROUP_CODE);
        op_o.sense = instr_i[SENSE_B];
        op_o.mask  = instr_i[CC_W-1:0];
    end
endmodule

// File: rtl/ccop_apply.sv
module ccop_apply
    import ccop_pkg::*;
(
    input  cc_t    cur_i,
    input  cc_op_t op_i,
    input  logic   en_i,
    output cc_t    nxt_o
);
    for (genvar b = 0; b < CC_W; b++) begin : g_bit
        assign nxt_o[b] = (en_i && op_i.mask[b]) ? op_i.sense : cur_i[b];
    end
endmodule

// File: rtl/ccop_unit.sv
module ccop_unit
    import ccop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] instr_i,
    input  logic              exec_i,
    output logic              match_o,
    output logic [CC_W-1:0]   flags_o
);
    cc_op_t    op;
    cc_t       applied;
    logic      upd_en;
    cc_state_t st_d, st_q;

    ccop_decode i_decode (
        .instr_i (instr_i),
        .op_o    (op)
    );

    assign upd_en = exec_i && op.hit;

    ccop_apply i_apply (
        .cur_i (st_q.flags),
        .op_i  (op),
        .en_i  (upd_en),
        .nxt_o (applied)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.flags = '0;
        end else begin
            st_d.flags = applied;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign match_o = op.hit;
    assign flags_o = st_q.flags;

    // R2
    set_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && match_o && instr_i[SENSE_B])
        |=> ((flags_o & $past(instr_i[CC_W-1:0])) == $past(instr_i[CC_W-1:0])));

    // R3
    clr_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && match_o && !instr_i[SENSE_B])
        |=> ((flags_o & $past(instr_i[CC_W-1:0])) == '0));

    // R4
    keep_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_i && match_o)
        |=> ((flags_o & ~$past(instr_i[CC_W-1:0])) ==
             ($past(flags_o) & ~$past(instr_i[CC_W-1:0]))));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(exec_i && match_o)) |=> $stable(flags_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags_o == '0));
endmodule

// File: tb/test_ccop_unit.sv
`timescale 1ns/1ps
module test_ccop_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] instr_i;
    logic        exec_i;
    logic        match_o;
    logic [3:0]  flags_o;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [3:0]  model = 4'h0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ccop_unit i_ccop_unit (
        .clk     (clk),
        .rst     (rst),
        .instr_i (instr_i),
        .exec_i  (exec_i),
        .match_o (match_o),
        .flags_o (flags_o)
    );

    function automatic logic is_group(input logic [15:0] w);
        return w[15:5] == 11'b00000000101;
    endfunction

    function automatic logic [3:0] next_flags(input logic [3:0] cur,
                                              input logic [15:0] w,
                                              input logic ex);
        logic [3:0] r;
        r = cur;
        if (ex && is_group(w)) begin
            if (w[4]) r = cur | w[3:0];
            else      r = cur & ~w[3:0];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] w, input logic ex, input string req);
        @(negedge clk);
        instr_i = w;
        exec_i  = ex;
        #1;
        check("R1", {3'b0, match_o}, {3'b0, is_group(w)});
        model = next_flags(model, w, ex);
        @(negedge clk);
        check(req, flags_o, model);
        exec_i = 1'b0;
    endtask

    task automatic do_reset(input logic [15:0] w, input logic ex);
        @(negedge clk);
        rst = 1'b1; instr_i = w; exec_i = ex;
        @(negedge clk);
        rst = 1'b0; exec_i = 1'b0;
        model = 4'h0;
        check("R9", flags_o, 4'h0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic        ex;
        void'($urandom(32'd7331));
        rst = 1'b1; instr_i = 16'h0; exec_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9", flags_o, 4'h0);

        // R6 set all then clear all
        step(16'o000277, 1'b1, "R6");
        // R5 empty masks keep all ones
        step(16'o000260, 1'b1, "R5");
        step(16'o000240, 1'b1, "R5");
        // R7 clear V and C only
        step(16'o000243, 1'b1, "R7");
        step(16'o000257, 1'b1, "R6");
        step(16'o000240, 1'b1, "R5");
        step(16'o000260, 1'b1, "R5");
        // R7 set N and Z only
        step(16'o000274, 1'b1, "R7");
        // R2 single flag set, R4 others kept
        step(16'o000261, 1'b1, "R2");
        step(16'o000252, 1'b1, "R4");
        // R3 single flag clear
        step(16'o000244, 1'b1, "R3");
        // R8 matching word without strobe
        step(16'o000277, 1'b0, "R8");
        step(16'o000257, 1'b0, "R8");
        // R8 neighbours of the group with strobe high
        step(16'o000300, 1'b1, "R8");
        step(16'o000237, 1'b1, "R8");
        step(16'o000220, 1'b1, "R8");
        step(16'o100277, 1'b1, "R8");
        step(16'o001257, 1'b1, "R8");
        // R9 reset wins over a strobed set-all
        step(16'o000277, 1'b1, "R6");
        do_reset(16'o000277, 1'b1);

        for (int i = 0; i < 400; i++) begin
            if ($urandom % 2) w = {11'b00000000101, 5'($urandom)};
            else              w = 16'($urandom);
            ex = ($urandom % 4) != 0;
            if (!(ex && is_group(w)))   step(w, ex, "R8");
            else if (w[3:0] == 4'h0)    step(w, ex, "R5");
            else if (w[4])              step(w, ex, "R2");
            else                        step(w, ex, "R3");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule